// File: doc/BRIEF.md
# Burst Array-Fill Writer

This block is a write-only AXI4 initiator that fills a run of 32-bit words in external memory so that every element holds its own index. Element 0 gets 0, element 1 gets 1, and so on up to the last element. Software or surrounding logic loads the base address into a target-side register and then pulses `start`. The block walks the run, sending one incrementing burst at a time on the write address, write data and write response channels.

Each burst is as long as three limits allow: the configured maximum burst length, the number of elements still to write, and the number of words left before the next 4 KB address page. When the run ends, the block raises `done` for one cycle and returns to idle. The base register keeps its value, so a later start with no new base write repeats the fill at the same place.

The base address must be word aligned.

Top module: `burst_fill_writer`

## Requirements
- R1: While reset is asserted and after it is released, `awValid`, `wValid`, `bReady`, `busy` and `done` are low.
- R2: Element k is written with the value k at byte address base + 4*k. Every beat has `wStrb` = 4'hF, and a run carries exactly NUM_ELEM beats.
- R3: Every write address request has `awBurst` = 2'b01 (incrementing) and `awSize` = 3'b010 (4 bytes), and `awLen` equals the burst's beat count minus one.
- R4: Each burst's beat count is the smallest of MAX_BURST, the elements remaining and the words left before the next 4 KB boundary. With a page-aligned base and the defaults (1000 elements, 64 beats), the run is 15 bursts of 64 followed by one of 40.
- R5: No burst crosses a 4 KB address boundary.
- R6: `wLast` is high on the final beat of each burst and low on all other beats.
- R7: Only one burst is in flight. `awValid` stays low from the accepted address until that burst's write response has been accepted. `wValid` is high only after the burst's address has been accepted, and `bReady` is high while the response is awaited.
- R8: Once `awValid` or `wValid` is raised, it and its payload stay unchanged until the matching ready is seen.
- R9: A `start` pulse while `busy` is ignored, and the current run continues unchanged. A base write while `busy` does not alter the current run's addresses but is stored and used by the next start.
- R10: When a base write and `start` fall in the same cycle while idle, the run uses the newly written base.
- R11: `done` is a single-cycle pulse in the cycle after the run's last write response handshake, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBaseWe | input | 1 | Base register write enable |
| cfgBaseData | input | 64 | Base address value to store |
| start | input | 1 | Begin a fill run (accepted only while idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at run end |
| awAddr | output | 64 | Burst start address |
| awLen | output | 8 | Beats in burst minus one |
| awSize | output | 3 | Beat size code (4 bytes) |
| awBurst | output | 2 | Burst type (incrementing) |
| awValid | output | 1 | Address request valid |
| awReady | input | 1 | Address request accepted |
| wData | output | 32 | Beat data (element index) |
| wStrb | output | 4 | Byte strobes |
| wLast | output | 1 | Final beat of burst |
| wValid | output | 1 | Beat valid |
| wReady | input | 1 | Beat accepted |
| bResp | input | 2 | Write response code (not examined) |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Ready for write response |

## Verification
Two functions can meet in one cycle: loading a new base value into the register, and the start that copies the base into the running address. The collision is provoked by driving `cfgBaseWe` and `start` in the same idle cycle with a value different from the stored one. It is judged by checking that every burst address of that run derives from the new value.

A second overlap places a start pulse and a base write in the middle of a run. The bench then checks that the remaining addresses still follow the old base and that the next run follows the poked one. Handshake stalls on all three channels and a base 16 bytes below a page end drive the stability and page-split rules.

// File: rtl/fill_pkg.sv
package fill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RESP
  } fillState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // copy base into running address, clear index
    logic awFire;  // address accepted: latch burst beat count
    logic wFire;   // beat accepted: advance index and address
  } fillStrobe_t;

  localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/fill_datapath.sv
module fill_datapath
  import fill_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 32,
  parameter int NUM_ELEM   = 1000,
  parameter int MAX_BURST  = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrobe_t       strb,
  input  logic              cfgBaseWe,
  input  logic [ADDR_W-1:0] cfgBaseData,
  output logic [ADDR_W-1:0] awAddr,
  output logic [7:0]        awLen,
  output logic [DATA_W-1:0] wData,
  output logic              lastBeat,
  output logic              moreLeft
);

  localparam int BYTES  = DATA_W / 8;
  localparam int SHIFT  = $clog2(BYTES);
  localparam int CNT_W  = $clog2(NUM_ELEM + 1);
  localparam int LEN_W  = $clog2(MAX_BURST + 1);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  elemIdx;
  logic [LEN_W-1:0]  beatCnt;

  logic [31:0] remBeats;
  logic [31:0] pageBeats;
  logic [31:0] pickBeats;

  // burst length: smallest of cap, remaining elements, words to page end
  always_comb begin
    remBeats  = 32'(NUM_ELEM) - 32'(elemIdx);
    pageBeats = (32'(PAGE_BYTES) - 32'(curAddr[PAGE_W-1:0])) >> SHIFT;
    pickBeats = 32'(MAX_BURST);
    if (remBeats < pickBeats)  pickBeats = remBeats;
    if (pageBeats < pickBeats) pickBeats = pageBeats;
  end

  assign awAddr   = curAddr;
  assign awLen    = 8'(pickBeats - 32'd1);
  assign wData    = DATA_W'(elemIdx);
  assign lastBeat = (beatCnt == LEN_W'(1));
  assign moreLeft = (elemIdx != CNT_W'(NUM_ELEM));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
    end else if (cfgBaseWe) begin
      baseReg <= cfgBaseData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      elemIdx <= '0;
      beatCnt <= '0;
    end else begin
      if (strb.load) begin
        // a same-cycle base write takes effect for this run
        curAddr <= cfgBaseWe ? cfgBaseData : baseReg;
        elemIdx <= '0;
      end
      if (strb.awFire) begin
        beatCnt <= LEN_W'(pickBeats);
      end
      if (strb.wFire) begin
        curAddr <= curAddr + ADDR_W'(BYTES);
        elemIdx <= elemIdx + CNT_W'(1);
        beatCnt <= beatCnt - LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl
  import fill_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        awReady,
  input  logic        wReady,
  input  logic        bValid,
  input  logic        lastBeat,
  input  logic        moreLeft,
  output fillStrobe_t strb,
  output logic        awValid,
  output logic        wValid,
  output logic        bReady,
  output logic        busy,
  output logic        done
);

  fillState_t state, stateNxt;
  logic       doneQ;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNxt  = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (awReady) begin
          strb.awFire = 1'b1;
          stateNxt    = ST_DATA;
        end
      end
      ST_DATA: begin
        if (wReady) begin
          strb.wFire = 1'b1;
          if (lastBeat) stateNxt = ST_RESP;
        end
      end
      ST_RESP: begin
        if (bValid) stateNxt = moreLeft ? ST_ADDR : ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNxt;
      doneQ <= (state == ST_RESP) && bValid && !moreLeft;
    end
  end

  assign awValid = (state == ST_ADDR);
  assign wValid  = (state == ST_DATA);
  assign bReady  = (state == ST_RESP);
  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;

endmodule

// File: rtl/burst_fill_writer.sv
module burst_fill_writer
  import fill_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 32,
  parameter int NUM_ELEM   = 1000,
  parameter int MAX_BURST  = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgBaseWe,
  input  logic [ADDR_W-1:0] cfgBaseData,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] awAddr,
  output logic [7:0]        awLen,
  output logic [2:0]        awSize,
  output logic [1:0]        awBurst,
  output logic              awValid,
  input  logic              awReady,
  output logic [DATA_W-1:0] wData,
  output logic [DATA_W/8-1:0] wStrb,
  output logic              wLast,
  output logic              wValid,
  input  logic              wReady,
  input  logic [1:0]        bResp,
  input  logic              bValid,
  output logic              bReady
);

  localparam int BYTES = DATA_W / 8;

  fillStrobe_t strb;
  logic        lastBeat;
  logic        moreLeft;
  logic        unusedResp;

  fill_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .awReady  (awReady),
    .wReady   (wReady),
    .bValid   (bValid),
    .lastBeat (lastBeat),
    .moreLeft (moreLeft),
    .strb     (strb),
    .awValid  (awValid),
    .wValid   (wValid),
    .bReady   (bReady),
    .busy     (busy),
    .done     (done)
  );

  fill_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_ELEM   (NUM_ELEM),
    .MAX_BURST  (MAX_BURST),
    .PAGE_BYTES (PAGE_BYTES)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgBaseWe   (cfgBaseWe),
    .cfgBaseData (cfgBaseData),
    .awAddr      (awAddr),
    .awLen       (awLen),
    .wData       (wData),
    .lastBeat    (lastBeat),
    .moreLeft    (moreLeft)
  );

  assign awSize     = 3'($clog2(BYTES));
  assign awBurst    = BURST_INCR;
  assign wStrb      = '1;
  assign wLast      = lastBeat;
  assign unusedResp = ^bResp;

endmodule

// File: rtl/fill_writer_chk.sv
module fill_writer_chk #(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 32,
  parameter int MAX_BURST  = 64,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rstN,
  input logic              awValid,
  input logic              awReady,
  input logic [ADDR_W-1:0] awAddr,
  input logic [7:0]        awLen,
  input logic              wValid,
  input logic              wReady,
  input logic [DATA_W-1:0] wData,
  input logic              wLast,
  input logic              bValid,
  input logic              bReady,
  input logic              busy,
  input logic              done
);

  localparam int BYTES  = DATA_W / 8;
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [1:0] inFlight;
  logic [8:0] beatsSeen;
  logic [7:0] lenHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight  <= '0;
      beatsSeen <= '0;
      lenHold   <= '0;
    end else begin
      if (awValid && awReady) begin
        inFlight  <= inFlight + 2'd1;
        beatsSeen <= '0;
        lenHold   <= awLen;
      end else if (bValid && bReady) begin
        inFlight <= inFlight - 2'd1;
      end
      if (wValid && wReady) beatsSeen <= beatsSeen + 9'd1;
    end
  end

  // R7
  aw_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> inFlight == 2'd0);

  // R7
  w_after_aw_chk: assert property (@(posedge clk) disable iff (!rstN)
    wValid |-> inFlight == 2'd1);

  // R8
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !awReady |=> awValid && $stable(awAddr) && $stable(awLen));

  // R8
  w_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wValid && !wReady |=> wValid && $stable(wData) && $stable(wLast));

  // R6
  last_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    wValid && wReady |-> wLast == (beatsSeen == {1'b0, lenHold}));

  // R5
  page_chk: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> (32'(awAddr[PAGE_W-1:0]) + (32'(awLen) + 32'd1) * BYTES) <= 32'(PAGE_BYTES));

  // R4
  len_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> 32'(awLen) < 32'(MAX_BURST));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

bind burst_fill_writer fill_writer_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .MAX_BURST  (MAX_BURST),
  .PAGE_BYTES (PAGE_BYTES)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .awValid (awValid),
  .awReady (awReady),
  .awAddr  (awAddr),
  .awLen   (awLen),
  .wValid  (wValid),
  .wReady  (wReady),
  .wData   (wData),
  .wLast   (wLast),
  .bValid  (bValid),
  .bReady  (bReady),
  .busy    (busy),
  .done    (done)
);

// File: tb/burst_fill_writer_test.sv
module burst_fill_writer_test;

  localparam int NUM  = 1000;
  localparam int MAXB = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgBaseWe = 1'b0;
  logic [63:0] cfgBaseData = '0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [63:0] awAddr;
  logic [7:0]  awLen;
  logic [2:0]  awSize;
  logic [1:0]  awBurst;
  logic        awValid;
  logic        awReady = 1'b0;
  logic [31:0] wData;
  logic [3:0]  wStrb;
  logic        wLast, wValid;
  logic        wReady = 1'b0;
  logic [1:0]  bResp = 2'b00;
  logic        bValid = 1'b0;
  logic        bReady;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  burst_fill_writer #(
    .ADDR_W(64), .DATA_W(32), .NUM_ELEM(NUM), .MAX_BURST(MAXB), .PAGE_BYTES(4096)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgBaseWe(cfgBaseWe), .cfgBaseData(cfgBaseData),
    .start(start), .busy(busy), .done(done),
    .awAddr(awAddr), .awLen(awLen), .awSize(awSize), .awBurst(awBurst),
    .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wLast(wLast), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // mode 0: no base write, 1: write then start, 2: write and start together
  task automatic kick(input logic [63:0] base, input int mode);
    @(negedge clk);
    if (mode == 1) begin
      cfgBaseWe = 1'b1; cfgBaseData = base;
      @(negedge clk);
      cfgBaseWe = 1'b0;
    end
    start = 1'b1;
    if (mode == 2) begin cfgBaseWe = 1'b1; cfgBaseData = base; end
    @(negedge clk);
    start = 1'b0; cfgBaseWe = 1'b0;
  endtask

  // memory-side responder and checker for one full run
  task automatic serveRun(input logic [63:0] base, input int stall, input bit poke,
                          input logic [63:0] pokeBase, input string addrTag);
    longint      idx = 0;
    logic [63:0] addr = base;
    int          burstNo = 0;
    int          len, pg, guard;
    while (idx < NUM) begin
      len = MAXB;
      if (NUM - idx < len) len = int'(NUM - idx);
      pg = int'((64'd4096 - (addr & 64'hFFF)) / 4);
      if (pg < len) len = pg;
      guard = 0;
      while (!awValid && guard < 50) begin @(negedge clk); guard++; end
      check(awValid, "R7", "awValid after response", longint'(awValid), 1);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check(awValid && awAddr == addr, "R8", "aw held while stalled", awAddr, addr);
      end
      check(awAddr == addr, addrTag, "burst address", awAddr, addr);
      check(awLen == 8'(len - 1), "R4", "burst length", awLen, len - 1);
      check(awBurst == 2'b01 && awSize == 3'b010, "R3", "burst type/size",
            {awBurst, awSize}, 5'b01010);
      check((awAddr[11:0] + (awLen + 1) * 4) <= 4096, "R5", "page crossing",
            awAddr, addr);
      awReady = 1'b1;
      @(negedge clk);
      awReady = 1'b0;
      for (int b = 0; b < len; b++) begin
        if (stall > 0) begin
          wReady = 1'b0;
          for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check(!awValid, "R7", "no address during data", awValid, 0);
            check(wValid && wData == 32'(idx), "R8", "beat held", wData, idx);
          end
        end
        wReady = 1'b1;
        check(wValid, "R7", "wValid after address", wValid, 1);
        check(wData == 32'(idx), "R2", "beat data", wData, idx);
        check(wStrb == 4'hF, "R2", "strobes", wStrb, 4'hF);
        check(wLast == (b == len - 1), "R6", "wLast", wLast, (b == len - 1));
        @(negedge clk);
        idx++;
        addr += 64'd4;
      end
      wReady = 1'b0;
      if (poke && burstNo == 0) begin
        start = 1'b1; cfgBaseWe = 1'b1; cfgBaseData = pokeBase;
        @(negedge clk);
        start = 1'b0; cfgBaseWe = 1'b0;
        check(!awValid && busy, "R9", "start while busy ignored", awValid, 0);
      end
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check(!awValid && !wValid, "R7", "quiet while awaiting response",
              {awValid, wValid}, 0);
      end
      check(bReady, "R7", "bReady while awaiting response", bReady, 1);
      bValid = 1'b1;
      @(negedge clk);
      bValid = 1'b0;
      burstNo++;
    end
    check(idx == NUM, "R2", "beat total", idx, NUM);
    check(done && !busy, "R11", "done pulse after last response", {done, busy}, 2'b10);
    @(negedge clk);
    check(!done, "R11", "done lasts one cycle", done, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!awValid && !wValid && !bReady && !busy && !done, "R1", "outputs in reset",
          {awValid, wValid, bReady, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!awValid && !wValid && !bReady && !busy && !done, "R1", "outputs after reset",
          {awValid, wValid, bReady, busy, done}, 0);
  endtask

  // R4: page-aligned base gives 15 bursts of 64 then one of 40
  task automatic testAligned();
    kick(64'h0000_0001_0000_0000, 1);
    serveRun(64'h0000_0001_0000_0000, 0, 1'b0, '0, "R2");
  endtask

  // R5: 16 bytes below a page end forces a 4-beat first burst
  task automatic testBoundary();
    kick(64'h0000_0002_0000_0FF0, 1);
    serveRun(64'h0000_0002_0000_0FF0, 2, 1'b0, '0, "R5");
  endtask

  // R10: base write and start together; R9: start and base write mid-run
  task automatic testOverlap();
    kick(64'h0000_0003_0000_0100, 2);
    serveRun(64'h0000_0003_0000_0100, 1, 1'b1, 64'h0000_0004_0000_0000, "R10");
  endtask

  // R9: the poked base is used by the next start
  task automatic testReuse();
    kick('0, 0);
    serveRun(64'h0000_0004_0000_0000, 0, 1'b0, '0, "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testAligned();
    testBoundary();
    testOverlap();
    testReuse();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule